// File: doc/BRIEF.md
# Vertical Laplacian Sharpening Filter

This block sharpens an 8-bit raster image along the sub-scan (vertical) direction. Pixels arrive one per clock in main-scan order, flagged by a valid strobe. Two full-line delay memories hold the two most recent lines. Each incoming pixel is therefore seen together with the pixel in the same column one line earlier (the centre pixel N) and two lines earlier (the upper pixel A). The incoming pixel itself is the lower pixel B.

For every column the block forms the second difference 2N − (A + B). It scales that difference by a programmable gain K and adds the result back onto N. This is the same as N + K·((N − A) + (N − B)). The product is rounded to the nearest integer before the add, and the sum is saturated to 0..255.

A frame restart input clears the column position and the line count. Output only starts once two complete lines of the new frame have been stored. The line length is a parameter.

Top module: `vline_sharpen`

## Requirements
- R1: For an accepted pixel B with centre N and upper A, the output equals clamp(N + round(K·(2N − A − B) / 16)), where `coef_k` is unsigned with bits [7:4] the integer part and bits [3:0] the fraction, sampled together with the same pixel.
- R2: A is the pixel accepted at the same column index two lines earlier and N the one accepted one line earlier, within the current frame; column indices run 0..LINE_LEN−1 and wrap to 0 after LINE_LEN−1.
- R3: Results below 0 give 0 and results above 255 give 255.
- R4: A result sampled on rising edge E is presented on `pix_out`/`pix_out_vld` right after edge E+2 and is held for one cycle, with `pix_out_vld` high.
- R5: After reset or a frame restart, pixels of the first two lines produce no output; `pix_out_vld` is never high without a corresponding accepted pixel.
- R6: When `frame_restart` is high, the column index and line count return to zero and a pixel offered in that same cycle is discarded.
- R7: A cycle with `pix_in_vld` low does not advance the column index and produces no output.
- R8: While reset is asserted and right after it, `pix_out_vld` and `pix_out` are 0.
- R9: With K = 0 the output equals the centre pixel N.
- R10: Rounding adds one half and then floors, so exact halves round toward +infinity, including for negative products.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_restart | input | 1 | Synchronous restart of column and line position |
| coef_k | input | 8 | Gain K, unsigned, 4 integer and 4 fraction bits |
| pix_in_vld | input | 1 | Input pixel strobe |
| pix_in | input | 8 | Input pixel (lower line B) |
| pix_out_vld | output | 1 | Output pixel strobe |
| pix_out | output | 8 | Sharpened pixel |

## Verification
Each output is due exactly two edges after the edge that samples its input pixel. Counting the sampling edge, it becomes visible after the third rising edge. The bench notes which edge samples each pixel it drives. It files the reference result in a slot keyed by the falling edge just after that third edge. At every falling edge it compares the outputs with the slot for that edge. An early, late, missing or surplus strobe therefore shows up as a mismatch at its own cycle, and so does a wrong value. Restart, stall and start-up cases rely on the same slotting: an empty slot means `pix_out_vld` must be low there.

// File: rtl/vls_pkg.sv
package vls_pkg;
  localparam int PIX_W   = 8;
  localparam int K_W     = 8;
  localparam int K_FRAC  = 4;
  localparam int N_DELAY = 2;

  typedef logic [PIX_W-1:0] pix_t;

  typedef struct packed {
    pix_t             upper;   // two lines back
    pix_t             centre;  // one line back
    pix_t             lower;   // live input
    logic [K_W-1:0]   gain;
  } tap_t;
endpackage

// File: rtl/vls_line_ram.sv
module vls_line_ram
  import vls_pkg::*;
#(
  parameter int DEPTH = 1024,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  pix_t          wr_data,
  output pix_t          rd_data
);
  pix_t mem [DEPTH];

  // Old content at addr is read in the same cycle it is overwritten.
  assign rd_data = mem[addr];

  always_ff @(posedge clk) begin
    if (wr_en) mem[addr] <= wr_data;
  end
endmodule

// File: rtl/vls_scan_ctrl.sv
module vls_scan_ctrl #(
  parameter int LINE_LEN = 1024,
  localparam int AW      = (LINE_LEN > 1) ? $clog2(LINE_LEN) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          pix_valid,
  output logic          accept,
  output logic [AW-1:0] col,
  output logic          window_full
);
  localparam logic [AW-1:0] LAST = AW'(LINE_LEN - 1);

  logic [AW-1:0] col_q, col_d;
  logic [1:0]    lines_q, lines_d;

  always_comb begin
    col_d   = col_q;
    lines_d = lines_q;
    if (restart) begin
      col_d   = '0;
      lines_d = '0;
    end else if (pix_valid) begin
      if (col_q == LAST) begin
        col_d = '0;
        if (lines_q != 2'd2) lines_d = lines_q + 2'd1;
      end else begin
        col_d = col_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q   <= '0;
      lines_q <= '0;
    end else begin
      col_q   <= col_d;
      lines_q <= lines_d;
    end
  end

  assign accept      = pix_valid && !restart;
  assign col         = col_q;
  assign window_full = (lines_q == 2'd2);

  p_restart_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (col_q == '0) && (lines_q == 2'd0));

  p_stall_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!pix_valid && !restart) |=> $stable(col_q) && $stable(lines_q));

  p_column_wraps_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && col_q == LAST) |=> (col_q == '0));

  p_lines_saturate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    lines_q != 2'd3);
endmodule

// File: rtl/vls_lap_core.sv
module vls_lap_core
  import vls_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tap_valid,
  input  tap_t tap,
  output logic out_valid,
  output pix_t out_pix
);
  localparam int LAP_W  = PIX_W + 3;
  localparam int PROD_W = LAP_W + K_W + 1;
  localparam int SUM_W  = PROD_W + 1;
  localparam int HALF   = 1 << (K_FRAC - 1);
  localparam logic signed [SUM_W-1:0] MAXV = SUM_W'((1 << PIX_W) - 1);

  logic signed [LAP_W-1:0]  up_s, mid_s, low_s, lap;
  logic signed [PROD_W-1:0] gain_s, prod, rnd;
  logic signed [SUM_W-1:0]  sum_d, sum_q;
  logic                     v2_q;
  logic                     v3_q;
  pix_t                     pix_d, pix_q;

  // Stage 2: second difference, scaling, rounding, add-back
  always_comb begin
    up_s   = signed'(LAP_W'(tap.upper));
    mid_s  = signed'(LAP_W'(tap.centre));
    low_s  = signed'(LAP_W'(tap.lower));
    lap    = (mid_s <<< 1) - up_s - low_s;
    gain_s = signed'(PROD_W'(tap.gain));
    prod   = PROD_W'(lap) * gain_s;
    rnd    = (prod + PROD_W'(HALF)) >>> K_FRAC;
    sum_d  = tap_valid ? (SUM_W'(rnd) + signed'(SUM_W'(tap.centre))) : sum_q;
  end

  // Stage 3: saturation
  always_comb begin
    pix_d = pix_q;
    if (v2_q) begin
      if (sum_q < 0)         pix_d = '0;
      else if (sum_q > MAXV) pix_d = '1;
      else                   pix_d = sum_q[PIX_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v2_q  <= 1'b0;
      sum_q <= '0;
      v3_q  <= 1'b0;
      pix_q <= '0;
    end else begin
      v2_q  <= tap_valid;
      sum_q <= sum_d;
      v3_q  <= v2_q;
      pix_q <= pix_d;
    end
  end

  assign out_valid = v3_q;
  assign out_pix   = pix_q;

  p_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tap_valid |-> ##2 out_valid);

  p_no_spurious_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !tap_valid |-> ##2 !out_valid);

  p_sat_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (v2_q && sum_q < 0) |=> (out_pix == '0));

  p_sat_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (v2_q && sum_q > MAXV) |=> (out_pix == '1));

  p_in_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (v2_q && sum_q >= 0 && sum_q <= MAXV) |=> (out_pix == $past(sum_q[PIX_W-1:0])));
endmodule

// File: rtl/vline_sharpen.sv
module vline_sharpen
  import vls_pkg::*;
#(
  parameter int LINE_LEN = 1024
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frame_restart,
  input  logic [7:0] coef_k,
  input  logic       pix_in_vld,
  input  logic [7:0] pix_in,
  output logic       pix_out_vld,
  output logic [7:0] pix_out
);
  localparam int AW = (LINE_LEN > 1) ? $clog2(LINE_LEN) : 1;

  logic          accept;
  logic          window_full;
  logic [AW-1:0] col;
  pix_t          chain [N_DELAY+1];
  tap_t          tap_d, tap_q;
  logic          tap_vld_q;

  vls_scan_ctrl #(.LINE_LEN(LINE_LEN)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .restart     (frame_restart),
    .pix_valid   (pix_in_vld),
    .accept      (accept),
    .col         (col),
    .window_full (window_full)
  );

  assign chain[0] = pix_in;

  // Cascaded line delays sharing one column pointer
  for (genvar g = 0; g < N_DELAY; g++) begin : g_line
    vls_line_ram #(.DEPTH(LINE_LEN)) u_ram (
      .clk     (clk),
      .wr_en   (accept),
      .addr    (col),
      .wr_data (chain[g]),
      .rd_data (chain[g+1])
    );
  end

  // Stage 1: capture the vertical window with its gain
  always_comb begin
    tap_d = tap_q;
    if (accept) begin
      tap_d.lower  = chain[0];
      tap_d.centre = chain[1];
      tap_d.upper  = chain[2];
      tap_d.gain   = coef_k;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tap_q     <= '0;
      tap_vld_q <= 1'b0;
    end else begin
      tap_q     <= tap_d;
      tap_vld_q <= accept && window_full;
    end
  end

  vls_lap_core u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .tap_valid (tap_vld_q),
    .tap       (tap_q),
    .out_valid (pix_out_vld),
    .out_pix   (pix_out)
  );

  p_gate_on_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !window_full) |=> !tap_vld_q);

  p_restart_drops_r6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_restart |=> !tap_vld_q);
endmodule

// File: tb/vline_sharpen_bench.sv
module vline_sharpen_bench;
  localparam int LEN = 8;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       frame_restart;
  logic [7:0] coef_k;
  logic       pix_in_vld;
  logic [7:0] pix_in;
  logic       pix_out_vld;
  logic [7:0] pix_out;

  vline_sharpen #(.LINE_LEN(LEN)) u_vline_sharpen (
    .clk           (clk),
    .rst_n         (rst_n),
    .frame_restart (frame_restart),
    .coef_k        (coef_k),
    .pix_in_vld    (pix_in_vld),
    .pix_in        (pix_in),
    .pix_out_vld   (pix_out_vld),
    .pix_out       (pix_out)
  );

  always #4 clk = ~clk;

  int    cyc = 0;
  int    checks = 0;
  int    errors = 0;
  bit    mon_on = 1'b0;
  bit    done = 1'b0;
  string cur_req = "R8";

  bit exp_v [64];
  int exp_d [64];
  int row2 [LEN];
  int row1 [LEN];
  int row0 [LEN];
  int col_m = 0;
  int lines_m = 0;
  int kval = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int ref_pix(int a, int n, int b, int k);
    int lap = 2 * n - a - b;
    int p   = k * lap;
    int r   = (p + 8) >>> 4;
    int s   = n + r;
    if (s < 0)   s = 0;
    if (s > 255) s = 255;
    return s;
  endfunction

  // Drive one cycle; the bench model tracks rows and files the expected output.
  task automatic drive(input bit v, input bit rs, input int pix);
    int slot;
    @(negedge clk);
    pix_in_vld    = v;
    frame_restart = rs;
    pix_in        = 8'(pix);
    coef_k        = 8'(kval);
    if (rs) begin
      col_m   = 0;
      lines_m = 0;
    end else if (v) begin
      if (lines_m >= 2) begin
        slot = (cyc + 3) % 64;
        exp_v[slot] = 1'b1;
        exp_d[slot] = ref_pix(row2[col_m], row1[col_m], pix, kval);
      end
      row0[col_m] = pix;
      col_m++;
      if (col_m == LEN) begin
        for (int i = 0; i < LEN; i++) begin
          row2[i] = row1[i];
          row1[i] = row0[i];
        end
        col_m = 0;
        if (lines_m < 2) lines_m++;
      end
    end
  endtask

  always @(negedge clk) begin
    int slot;
    if (mon_on) begin
      slot = cyc % 64;
      if (exp_v[slot] || pix_out_vld) begin
        checks++;
        if (pix_out_vld !== exp_v[slot] ||
            (exp_v[slot] && int'(pix_out) != exp_d[slot])) begin
          errors++;
          $display("FAIL %s: cycle %0d out_vld=%0b out=%0d expected vld=%0b out=%0d",
                   cur_req, cyc, pix_out_vld, pix_out, exp_v[slot], exp_d[slot]);
        end
      end
      exp_v[slot] = 1'b0;
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(1'b0, 1'b0, 0);
  endtask

  task automatic check_now(input string req, input bit v, input int d);
    checks++;
    if (pix_out_vld !== v || int'(pix_out) != d) begin
      errors++;
      $display("FAIL %s: out_vld=%0b out=%0d expected vld=%0b out=%0d",
               req, pix_out_vld, pix_out, v, d);
    end
  endtask

  task automatic t_reset();
    cur_req = "R8";
    check_now("R8", 1'b0, 0);
    @(negedge clk);
    check_now("R8", 1'b0, 0);
  endtask

  // R1 R2 R4 R5: gain 1.5, four lines of a varied pattern
  task automatic t_basic();
    cur_req = "R1/R2/R4/R5";
    kval = 8'h18;
    drive(1'b0, 1'b1, 0);
    for (int l = 0; l < 4; l++)
      for (int c = 0; c < LEN; c++)
        drive(1'b1, 1'b0, (l * 53 + c * 29 + 7) & 255);
    idle(5);
  endtask

  // R9: zero gain passes the centre line
  task automatic t_kzero();
    cur_req = "R9";
    kval = 0;
    drive(1'b0, 1'b1, 0);
    for (int l = 0; l < 3; l++)
      for (int c = 0; c < LEN; c++)
        drive(1'b1, 1'b0, (l * 91 + c * 17 + 3) & 255);
    idle(5);
  endtask

  // R3: strong gain on peaks and valleys
  task automatic t_clamp();
    cur_req = "R3";
    kval = 8'hF0;
    drive(1'b0, 1'b1, 0);
    for (int l = 0; l < 3; l++)
      for (int c = 0; c < LEN; c++)
        drive(1'b1, 1'b0, (((l + c) % 2) == 0) ? 255 : 0);
    idle(5);
  endtask

  // R10: half gain with odd second differences of both signs
  task automatic t_round();
    int up  [4] = '{0, 1, 13, 11};
    int mid [4] = '{1, 0, 10, 10};
    int low [4] = '{1, 0, 10, 10};
    cur_req = "R10";
    kval = 8'h08;
    drive(1'b0, 1'b1, 0);
    for (int c = 0; c < LEN; c++) drive(1'b1, 1'b0, up[c % 4]);
    for (int c = 0; c < LEN; c++) drive(1'b1, 1'b0, mid[c % 4]);
    for (int c = 0; c < LEN; c++) drive(1'b1, 1'b0, low[c % 4]);
    idle(5);
  endtask

  // R7: stalls inside lines
  task automatic t_gaps();
    cur_req = "R7";
    kval = 8'h10;
    drive(1'b0, 1'b1, 0);
    for (int l = 0; l < 3; l++)
      for (int c = 0; c < LEN; c++) begin
        drive(1'b1, 1'b0, (l * 71 + c * 13 + 40) & 255);
        if (c % 3 == 1) idle(2);
      end
    idle(5);
  endtask

  // R6: restart in mid-line with a pixel offered in the restart cycle
  task automatic t_restart();
    cur_req = "R6";
    kval = 8'h10;
    drive(1'b0, 1'b1, 0);
    for (int c = 0; c < LEN + LEN / 2; c++) drive(1'b1, 1'b0, (c * 37 + 5) & 255);
    drive(1'b1, 1'b1, 200);
    for (int l = 0; l < 3; l++)
      for (int c = 0; c < LEN; c++)
        drive(1'b1, 1'b0, (l * 19 + c * 61 + 100) & 255);
    idle(5);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) begin
      exp_v[i] = 1'b0;
      exp_d[i] = 0;
    end
    rst_n         = 1'b0;
    frame_restart = 1'b0;
    coef_k        = 8'h00;
    pix_in_vld    = 1'b0;
    pix_in        = 8'h00;
    repeat (3) @(negedge clk);
    check_now("R8", 1'b0, 0);
    rst_n  = 1'b1;
    mon_on = 1'b1;
    t_reset();
    t_basic();
    t_kzero();
    t_clamp();
    t_round();
    t_gaps();
    t_restart();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R4: watchdog at cycle %0d, expected completion before %0d", cyc, 20000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule